// File: doc/BRIEF.md
# Transaction Nesting and Lock Elision Controller

This block tracks transactional regions for one execution thread. A region opens in one of two styles. In the elided style an acquire hint on a lock address starts or deepens the region, and the controller tells the core whether that acquire may skip its real lock write. In the explicit style begin and end commands bracket the region, and an abort command with an 8-bit software code can end it early. The controller keeps the nesting depth, a small table of elided lock addresses and the status word of the most recent abort.

Any abort clears the whole region, whatever the nesting level. The controller then drops out of the transactional state and pulses a request to restart from the start of the outermost region. Saving and restoring registers and re-executing instructions happen outside this block. A test flag tells software whether execution is currently outside every region. At most one command is applied per cycle. If several are raised together, conflict wins, then abort, begin, end, acquire and release, in that order.

Top module: `tx_nest_ctrl`

## Requirements
- R1: After reset `inTx` is 0, `testFlag` is 1, `abortStatus` is 0, and `elideGrant` and `restartOuter` are 0.
- R2: `beginCmd` outside any region opens an explicit region. Each further `beginCmd` adds one nesting level. The region stays open (`inTx`=1) until as many `endCmd` as `beginCmd` have been applied, and ending it leaves `abortStatus` unchanged.
- R3: A `beginCmd`, or an elided acquire, arriving at depth MAX_DEPTH (default 7) aborts the region with status bit 3 (nesting overflow) set.
- R4: `acqValid` outside any region opens an elided region. In the cycle after any elided acquire, `elideGrant` is 1 for exactly one cycle.
- R5: An acquire of an address not in the lock table, when all LOCK_SLOTS (default 2) entries are taken, gives `elideGrant`=0 and does not abort. An acquire of an address already in the table is granted and adds one nesting level.
- R6: `relValid` closes one elided level only when `lockAddr` matches an address in the table. A non-matching release changes nothing. The region ends after the last matching release.
- R7: `abortCmd` inside an explicit region aborts with status bit 0 set and `abortCode` in bits 31:24. Outside a region, `abortCmd` has no effect on any output.
- R8: `conflict` inside any region aborts with status bit 1 set. Outside a region it has no effect.
- R9: Status bit 4 is set exactly when the abort happens at nesting depth 2 or more. Bits 23:6 and bit 2 are always 0, and bits 31:24 are 0 for any abort other than an explicit one.
- R10: `beginCmd` inside an elided region aborts with status bit 5 set, so that the outer region is re-run without elision.
- R11: Acquire and release hints inside an explicit region are ignored: no grant and no change of depth.
- R12: On an abort, `inTx` falls and `abortStatus` takes its new value at the same clock edge, and `restartOuter` is 1 for exactly that one following cycle. `abortStatus` holds its value until the next abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| acqValid | input | 1 | Acquire hint on `lockAddr` |
| relValid | input | 1 | Release hint on `lockAddr` |
| lockAddr | input | ADDR_W | Lock address of the hint |
| beginCmd | input | 1 | Explicit region begin |
| endCmd | input | 1 | Explicit region end |
| abortCmd | input | 1 | Explicit abort |
| abortCode | input | 8 | Software code carried by the abort |
| conflict | input | 1 | Conflict from the memory system |
| inTx | output | 1 | Inside a transactional region |
| testFlag | output | 1 | 1 when outside every region |
| elideGrant | output | 1 | Previous acquire was elided |
| restartOuter | output | 1 | Restart the outermost region |
| abortStatus | output | 32 | Cause of the last abort |

## Verification
A wrong depth count appears at the ports as `inTx` falling one or more ends or releases too early or too late. It also appears as an overflow abort at the wrong nesting level, visible the cycle after the offending begin or acquire. A corrupted lock table shows up one cycle after the next acquire, as a wrong `elideGrant`, or as a release that fails to close its level. Mode errors show when a hint is honoured inside an explicit region, or when a begin inside an elided region fails to raise the bit-5 abort on the next cycle.

// File: rtl/tx_nest_pkg.sv
package tx_nest_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_ELIDE = 2'd1,
    MODE_EXPL  = 2'd2
  } txMode_e;

  // cause bit positions inside the status word
  localparam int CAUSE_W        = 6;
  localparam int CB_EXPLICIT    = 0;
  localparam int CB_CONFLICT    = 1;
  localparam int CB_NEST        = 3;
  localparam int CB_INNER       = 4;
  localparam int CB_MIXED       = 5;

  typedef struct packed {
    logic               insert;    // record lockAddr in a free slot
    logic               clearAll;  // drop every elided lock
    logic               latchStat; // capture a new abort status
    logic [CAUSE_W-1:0] cause;     // cause bits for the status word
  } txStrobe_t;

endpackage

// File: rtl/tx_lock_table.sv
module tx_lock_table
  import tx_nest_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LOCK_SLOTS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [ADDR_W-1:0] lockAddr,
  input  logic [7:0]        abortCode,
  output logic              hit,
  output logic              full,
  output logic [31:0]       abortStatus
);

  localparam int PAD_W = 32 - 8 - CAUSE_W;

  logic [LOCK_SLOTS-1:0] slotValid;
  logic [ADDR_W-1:0]     slotAddr [LOCK_SLOTS];
  logic [LOCK_SLOTS-1:0] slotMatch;
  logic [LOCK_SLOTS-1:0] freeOh;
  logic [31:0]           statusQ;

  // first free slot, one-hot
  always_comb begin
    logic taken;
    taken  = 1'b0;
    freeOh = '0;
    for (int i = 0; i < LOCK_SLOTS; i++) begin
      if (!slotValid[i] && !taken) begin
        freeOh[i] = 1'b1;
        taken     = 1'b1;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < LOCK_SLOTS; g++) begin : gSlot
      assign slotMatch[g] = slotValid[g] && (slotAddr[g] == lockAddr);

      always_ff @(posedge clk) begin
        if (!rstN || strobe.clearAll) begin
          slotValid[g] <= 1'b0;
          slotAddr[g]  <= '0;
        end else if (strobe.insert && !hit && freeOh[g]) begin
          slotValid[g] <= 1'b1;
          slotAddr[g]  <= lockAddr;
        end
      end
    end
  endgenerate

  assign hit  = |slotMatch;
  assign full = &slotValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
    end else if (strobe.latchStat) begin
      statusQ <= {(strobe.cause[CB_EXPLICIT] ? abortCode : 8'h00),
                  {PAD_W{1'b0}}, strobe.cause};
    end
  end

  assign abortStatus = statusQ;

endmodule

// File: rtl/tx_nest_fsm.sv
module tx_nest_fsm
  import tx_nest_pkg::*;
#(
  parameter int MAX_DEPTH = 7
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      acqValid,
  input  logic      relValid,
  input  logic      beginCmd,
  input  logic      endCmd,
  input  logic      abortCmd,
  input  logic      conflict,
  input  logic      hit,
  input  logic      full,
  output txStrobe_t strobe,
  output logic      inTx,
  output logic      elideGrant,
  output logic      restartOuter
);

  localparam int DEPTH_W = $clog2(MAX_DEPTH + 1);
  localparam logic [DEPTH_W-1:0] DEPTH_TOP = DEPTH_W'(MAX_DEPTH);
  localparam logic [DEPTH_W-1:0] DEPTH_ONE = DEPTH_W'(1);

  txMode_e           modeQ, modeD;
  logic [DEPTH_W-1:0] depthQ, depthD;
  logic              grantD, restartD;
  logic              doAbort;
  logic [CAUSE_W-1:0] causeD;

  always_comb begin
    modeD    = modeQ;
    depthD   = depthQ;
    grantD   = 1'b0;
    doAbort  = 1'b0;
    causeD   = '0;
    strobe   = '0;

    if (conflict && modeQ != MODE_IDLE) begin
      doAbort = 1'b1;
      causeD[CB_CONFLICT] = 1'b1;
    end else if (abortCmd && modeQ == MODE_EXPL) begin
      doAbort = 1'b1;
      causeD[CB_EXPLICIT] = 1'b1;
    end else if (beginCmd) begin
      unique case (modeQ)
        MODE_IDLE: begin
          modeD  = MODE_EXPL;
          depthD = DEPTH_ONE;
        end
        MODE_EXPL: begin
          if (depthQ == DEPTH_TOP) begin
            doAbort = 1'b1;
            causeD[CB_NEST] = 1'b1;
          end else begin
            depthD = depthQ + DEPTH_ONE;
          end
        end
        default: begin
          doAbort = 1'b1;
          causeD[CB_MIXED] = 1'b1;
        end
      endcase
    end else if (endCmd && modeQ == MODE_EXPL) begin
      depthD = depthQ - DEPTH_ONE;
      if (depthQ == DEPTH_ONE) begin
        modeD = MODE_IDLE;
      end
    end else if (acqValid) begin
      if (modeQ == MODE_IDLE) begin
        modeD         = MODE_ELIDE;
        depthD        = DEPTH_ONE;
        strobe.insert = 1'b1;
        grantD        = 1'b1;
      end else if (modeQ == MODE_ELIDE && (hit || !full)) begin
        if (depthQ == DEPTH_TOP) begin
          doAbort = 1'b1;
          causeD[CB_NEST] = 1'b1;
        end else begin
          depthD        = depthQ + DEPTH_ONE;
          strobe.insert = 1'b1;
          grantD        = 1'b1;
        end
      end
    end else if (relValid && modeQ == MODE_ELIDE && hit) begin
      depthD = depthQ - DEPTH_ONE;
      if (depthQ == DEPTH_ONE) begin
        modeD           = MODE_IDLE;
        strobe.clearAll = 1'b1;
      end
    end

    if (doAbort) begin
      causeD[CB_INNER] = (depthQ > DEPTH_ONE);
      modeD            = MODE_IDLE;
      depthD           = '0;
      strobe.insert    = 1'b0;
      strobe.clearAll  = 1'b1;
      strobe.latchStat = 1'b1;
      strobe.cause     = causeD;
    end
    restartD = doAbort;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ        <= MODE_IDLE;
      depthQ       <= '0;
      elideGrant   <= 1'b0;
      restartOuter <= 1'b0;
    end else begin
      modeQ        <= modeD;
      depthQ       <= depthD;
      elideGrant   <= grantD;
      restartOuter <= restartD;
    end
  end

  assign inTx = (modeQ != MODE_IDLE);

endmodule

// File: rtl/tx_nest_ctrl.sv
module tx_nest_ctrl
  import tx_nest_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MAX_DEPTH  = 7,
  parameter int LOCK_SLOTS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              acqValid,
  input  logic              relValid,
  input  logic [ADDR_W-1:0] lockAddr,
  input  logic              beginCmd,
  input  logic              endCmd,
  input  logic              abortCmd,
  input  logic [7:0]        abortCode,
  input  logic              conflict,
  output logic              inTx,
  output logic              testFlag,
  output logic              elideGrant,
  output logic              restartOuter,
  output logic [31:0]       abortStatus
);

  txStrobe_t strobe;
  logic      hit;
  logic      full;

  tx_nest_fsm #(.MAX_DEPTH(MAX_DEPTH)) u_fsm (
    .clk(clk), .rstN(rstN),
    .acqValid(acqValid), .relValid(relValid),
    .beginCmd(beginCmd), .endCmd(endCmd),
    .abortCmd(abortCmd), .conflict(conflict),
    .hit(hit), .full(full),
    .strobe(strobe), .inTx(inTx),
    .elideGrant(elideGrant), .restartOuter(restartOuter)
  );

  tx_lock_table #(.ADDR_W(ADDR_W), .LOCK_SLOTS(LOCK_SLOTS)) u_table (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .lockAddr(lockAddr), .abortCode(abortCode),
    .hit(hit), .full(full), .abortStatus(abortStatus)
  );

  assign testFlag = !inTx;

endmodule

// File: rtl/tx_nest_chk.sv
module tx_nest_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              acqValid,
  input logic              beginCmd,
  input logic              conflict,
  input logic              inTx,
  input logic              elideGrant,
  input logic              restartOuter,
  input logic [31:0]       abortStatus
);

  // R12
  restart_leaves_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    restartOuter |-> !inTx);

  // R4
  grant_inside_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    elideGrant |-> inTx);

  // R8
  conflict_aborts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (conflict && inTx) |=> (restartOuter && abortStatus[1]));

  // R12
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !restartOuter |-> $stable(abortStatus));

  // R2
  no_spurious_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inTx && !acqValid && !beginCmd) |=> !inTx);

  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (abortStatus[23:6] == '0) && !abortStatus[2]);

endmodule

bind tx_nest_ctrl tx_nest_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .acqValid(acqValid), .beginCmd(beginCmd),
  .conflict(conflict), .inTx(inTx), .elideGrant(elideGrant),
  .restartOuter(restartOuter), .abortStatus(abortStatus)
);

// File: tb/test_tx_nest_ctrl.sv
`timescale 1ns/1ps
module test_tx_nest_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        acqValid = 1'b0, relValid = 1'b0;
  logic [31:0] lockAddr = '0;
  logic        beginCmd = 1'b0, endCmd = 1'b0, abortCmd = 1'b0;
  logic [7:0]  abortCode = '0;
  logic        conflict = 1'b0;
  logic        inTx, testFlag, elideGrant, restartOuter;
  logic [31:0] abortStatus;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] expStat = '0;

  always #5 clk = ~clk;

  tx_nest_ctrl i_tx_nest_ctrl (
    .clk(clk), .rstN(rstN), .acqValid(acqValid), .relValid(relValid),
    .lockAddr(lockAddr), .beginCmd(beginCmd), .endCmd(endCmd),
    .abortCmd(abortCmd), .abortCode(abortCode), .conflict(conflict),
    .inTx(inTx), .testFlag(testFlag), .elideGrant(elideGrant),
    .restartOuter(restartOuter), .abortStatus(abortStatus)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // drive one command for one cycle; returns at the next falling edge
  task automatic step(input logic a, input logic r, input logic [31:0] ad,
                      input logic b, input logic e, input logic x,
                      input logic [7:0] c, input logic f);
    acqValid = a; relValid = r; lockAddr = ad;
    beginCmd = b; endCmd = e; abortCmd = x; abortCode = c; conflict = f;
    @(negedge clk);
    acqValid = 0; relValid = 0; beginCmd = 0; endCmd = 0;
    abortCmd = 0; conflict = 0;
  endtask

  task automatic doAcq(input logic [31:0] ad); step(1,0,ad,0,0,0,0,0); endtask
  task automatic doRel(input logic [31:0] ad); step(0,1,ad,0,0,0,0,0); endtask
  task automatic doBeg(); step(0,0,0,1,0,0,0,0); endtask
  task automatic doEnd(); step(0,0,0,0,1,0,0,0); endtask
  task automatic doAbt(input logic [7:0] c); step(0,0,0,0,0,1,c,0); endtask
  task automatic doCfl(); step(0,0,0,0,0,0,0,1); endtask
  task automatic idle(); step(0,0,0,0,0,0,0,0); endtask

  task automatic t_reset();
    chk("R1 inTx", {31'b0, inTx}, 0);
    chk("R1 testFlag", {31'b0, testFlag}, 1);
    chk("R1 status", abortStatus, 0);
    chk("R1 grant", {31'b0, elideGrant}, 0);
    chk("R1 restart", {31'b0, restartOuter}, 0);
  endtask

  task automatic t_explicit_nest();
    doBeg(); chk("R2 open", {31'b0, inTx}, 1);
    chk("R2 testFlag", {31'b0, testFlag}, 0);
    doBeg(); doBeg();
    doAcq(32'h40); chk("R11 no grant in explicit", {31'b0, elideGrant}, 0);
    doRel(32'h40);
    doEnd(); doEnd(); chk("R2 still open after 2 of 3 ends", {31'b0, inTx}, 1);
    doEnd(); chk("R11 R2 closed after 3 ends", {31'b0, inTx}, 0);
    chk("R2 status kept", abortStatus, expStat);
    chk("R2 no restart", {31'b0, restartOuter}, 0);
  endtask

  task automatic t_depth_overflow();
    for (int i = 0; i < 7; i++) doBeg();
    chk("R3 depth 7 open", {31'b0, inTx}, 1);
    chk("R3 no abort at 7", {31'b0, restartOuter}, 0);
    doBeg();
    expStat = 32'h0000_0018;
    chk("R3 overflow restart", {31'b0, restartOuter}, 1);
    chk("R3 R9 overflow status", abortStatus, expStat);
    chk("R12 out of region", {31'b0, inTx}, 0);
    idle();
    chk("R12 one-cycle restart", {31'b0, restartOuter}, 0);
    chk("R12 status held", abortStatus, expStat);
  endtask

  task automatic t_abort_cmd();
    doBeg(); doAbt(8'hA5);
    expStat = 32'hA500_0001;
    chk("R7 R9 explicit status", abortStatus, expStat);
    chk("R7 restart", {31'b0, restartOuter}, 1);
    chk("R7 closed", {31'b0, inTx}, 0);
    doAbt(8'h11);
    chk("R7 idle abort ignored status", abortStatus, expStat);
    chk("R7 idle abort no restart", {31'b0, restartOuter}, 0);
  endtask

  task automatic t_elide();
    doAcq(32'hA0); chk("R4 grant first", {31'b0, elideGrant}, 1);
    chk("R4 open", {31'b0, inTx}, 1);
    idle(); chk("R4 grant one cycle", {31'b0, elideGrant}, 0);
    doAcq(32'hB0); chk("R4 grant second lock", {31'b0, elideGrant}, 1);
    doAcq(32'hC0); chk("R5 no grant when full", {31'b0, elideGrant}, 0);
    chk("R5 no abort when full", {31'b0, restartOuter}, 0);
    chk("R5 region continues", {31'b0, inTx}, 1);
    doAcq(32'hA0); chk("R5 re-acquire granted", {31'b0, elideGrant}, 1);
    doRel(32'hC0); chk("R6 unmatched release ignored", {31'b0, inTx}, 1);
    doRel(32'hA0); doRel(32'hB0);
    chk("R6 open after 2 of 3 releases", {31'b0, inTx}, 1);
    doRel(32'hA0); chk("R6 closed on last release", {31'b0, inTx}, 0);
    chk("R6 commit keeps status", abortStatus, expStat);
    // table emptied: fresh locks fit again
    doAcq(32'hD0); doAcq(32'hE0);
    chk("R5 table cleared on commit", {31'b0, elideGrant}, 1);
    doRel(32'hE0); doRel(32'hD0);
    chk("R6 second region closed", {31'b0, inTx}, 0);
  endtask

  task automatic t_elide_overflow();
    for (int i = 0; i < 7; i++) doAcq(32'h77);
    chk("R3 elided depth 7 open", {31'b0, inTx}, 1);
    doAcq(32'h77);
    expStat = 32'h0000_0018;
    chk("R3 elided overflow status", abortStatus, expStat);
    chk("R3 elided overflow restart", {31'b0, restartOuter}, 1);
  endtask

  task automatic t_conflict();
    expStat = abortStatus;
    doCfl();
    chk("R8 idle conflict ignored", abortStatus, expStat);
    chk("R8 idle conflict no restart", {31'b0, restartOuter}, 0);
    doAcq(32'h10); doAcq(32'h10); doCfl();
    expStat = 32'h0000_0012;
    chk("R8 R9 nested conflict status", abortStatus, expStat);
    chk("R8 restart", {31'b0, restartOuter}, 1);
    doBeg(); doCfl();
    expStat = 32'h0000_0002;
    chk("R8 R9 flat conflict status", abortStatus, expStat);
  endtask

  task automatic t_mixed();
    doAcq(32'h20); doBeg();
    expStat = 32'h0000_0020;
    chk("R10 begin in elided status", abortStatus, expStat);
    chk("R10 restart", {31'b0, restartOuter}, 1);
    chk("R10 closed", {31'b0, inTx}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_explicit_nest();
    t_depth_overflow();
    t_abort_cmd();
    t_elide();
    t_elide_overflow();
    t_conflict();
    t_mixed();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule